// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block sits between an external display timing generator and a memory port. It drives a fixed 640 by 480 true-colour panel. For each visible pixel it presents the byte address of that pixel's 32-bit word, together with a fetch request. It then splits the returned word into 8-bit red, green and blue channels. The timing generator marks the start of each frame with a one-cycle pulse and steps through the visible pixels with an advance strobe. The scan position lives inside this block.

Software controls the block through two registers on a small word-indexed port. Index 0 places the frame buffer in memory; only the upper 11 address bits are stored, so the buffer is 2 MiB aligned. Index 1 holds an enable bit and a rotation bit. The rotation bit scans the frame backwards in both directions, which turns the picture by 180 degrees. Memory rows are 1024 words apart, so each visible row uses its first 640 words and 384 words are left unused. The base address and the rotation bit take effect only when a frame starts. The enable bit takes effect at once.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset, fetchReq is 0, red/green/blue are 0, and both registers read back as 0 (display off, not rotated, base 0).
- R2: A write to index 0 stores bits 31:21 of regWdata. Reading index 0 returns those bits in 31:21, with bits 20:0 always 0.
- R3: A write to index 1 stores bit 0 (enable) and bit 1 (rotate). Reading index 1 returns them in bits 1:0, with bits 31:2 always 0.
- R4: Without rotation, the pixel at row r, column c has fetchAddr = base + ((r*1024 + c) * 4). An advance strobe moves to the next column.
- R5: With rotation, the address uses row 479-r and column 639-c. The first pixel of a frame is therefore at base + 0x1DF9FC, and addresses fall by 4 per advance.
- R6: The advance after column 639 moves to column 0 of the next row, so the address jumps by 1024 words minus 639 words. Words 640..1023 of a row are never addressed.
- R7: The base and rotate settings are copied into the scan when frameStart is seen. Writes made during a frame do not change that frame's addresses.
- R8: While the enable bit is 0, fetchReq is 0 and red/green/blue are 0, starting with the cycle after the write that clears it. The scan position still advances.
- R9: While fetchReq is 1, red = pixWord[23:16], green = pixWord[15:8] and blue = pixWord[7:0]. Bits 31:24 have no effect.
- R10: The advance taken at the last pixel of a frame (row 479, column 639) ends the frame. fetchReq then stays 0, and further advances are ignored until the next frameStart.
- R11: frameStart always restarts the scan at the first pixel, even in mid-frame. If pixAdvance arrives in the same cycle, frameStart wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register index: 0 base, 1 control |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the register selected by regAddr |
| frameStart | input | 1 | One-cycle pulse that begins a frame |
| pixAdvance | input | 1 | Step to the next visible pixel |
| pixWord | input | 32 | Memory word for the address on fetchAddr |
| fetchAddr | output | 32 | Byte address of the current pixel word |
| fetchReq | output | 1 | Fetch request for fetchAddr |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The bench goes after the row boundary, where a design using the visible width as its stride would fetch 0x12200A00 instead of 0x12201000. It checks the rotated origin, where an off-by-one in the reflected coordinates would start the frame one word or one row away from 0x1DF9FC. A rotate and base write made mid-frame must leave the running frame alone; a design without the frame-start copy would jump the address at once. A design where pixAdvance wins over frameStart in the same cycle would start one pixel late. A smaller instance runs off the end of a frame: a scan that wraps instead of stopping would keep fetchReq high past the last pixel.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  parameter int DEF_ADDR_W      = 32;
  parameter int DEF_BASE_BITS   = 11;
  parameter int DEF_STRIDE_LOG2 = 10;
  parameter int DEF_H_PIX       = 640;
  parameter int DEF_V_ROWS      = 480;
  parameter int CHAN_W          = 8;
  parameter int NUM_CHAN        = 3;

  // strobes from register/control side into the scan datapath
  typedef struct packed {
    logic loadFrame;  // latch settings, restart at first pixel
    logic stepPix;    // move to the next visible pixel
    logic dispOn;     // live enable, gates request and colour
  } scanStrb_t;

endpackage

// File: rtl/scanout_ctrl.sv
module scanout_ctrl
  import scanout_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int BASE_BITS = DEF_BASE_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic                 regAddr,
  input  logic [ADDR_W-1:0]    regWdata,
  output logic [ADDR_W-1:0]    regRdata,
  input  logic                 frameStart,
  input  logic                 pixAdvance,
  output scanStrb_t            strb,
  output logic [BASE_BITS-1:0] baseHi,
  output logic                 rotSel
);

  localparam int LOW_W = ADDR_W - BASE_BITS;

  logic enSel;
  logic unusedWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi <= '0;
      enSel  <= 1'b0;
      rotSel <= 1'b0;
    end else if (regWe) begin
      if (!regAddr) begin
        baseHi <= regWdata[ADDR_W-1:LOW_W];
      end else begin
        enSel  <= regWdata[0];
        rotSel <= regWdata[1];
      end
    end
  end

  assign unusedWr = ^regWdata[LOW_W-1:2];

  always_comb begin
    if (regAddr) regRdata = {{(ADDR_W-2){1'b0}}, rotSel, enSel};
    else         regRdata = {baseHi, {LOW_W{1'b0}}};
  end

  always_comb begin
    strb.loadFrame = frameStart;
    strb.stepPix   = pixAdvance & ~frameStart;
    strb.dispOn    = enSel;
  end

endmodule

// File: rtl/scanout_datapath.sv
module scanout_datapath
  import scanout_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int BASE_BITS   = DEF_BASE_BITS,
  parameter int STRIDE_LOG2 = DEF_STRIDE_LOG2,
  parameter int H_PIX       = DEF_H_PIX,
  parameter int V_ROWS      = DEF_V_ROWS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrb_t            strb,
  input  logic [BASE_BITS-1:0] baseHi,
  input  logic                 rotSel,
  input  logic [31:0]          pixWord,
  output logic [ADDR_W-1:0]    fetchAddr,
  output logic                 fetchReq,
  output logic [CHAN_W-1:0]    red,
  output logic [CHAN_W-1:0]    green,
  output logic [CHAN_W-1:0]    blue
);

  localparam int COL_W = STRIDE_LOG2;
  localparam int ROW_W = ADDR_W - BASE_BITS - STRIDE_LOG2 - 2;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_PIX - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ROWS - 1);

  logic [BASE_BITS-1:0] shBase;
  logic                 shRot;
  logic [ROW_W-1:0]     rowQ, rowEff;
  logic [COL_W-1:0]     colQ, colEff;
  logic                 activeQ;
  logic [CHAN_W-1:0]    chan [NUM_CHAN];
  logic                 unusedAlpha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shBase  <= '0;
      shRot   <= 1'b0;
      rowQ    <= '0;
      colQ    <= '0;
      activeQ <= 1'b0;
    end else if (strb.loadFrame) begin
      shBase  <= baseHi;
      shRot   <= rotSel;
      rowQ    <= '0;
      colQ    <= '0;
      activeQ <= 1'b1;
    end else if (strb.stepPix && activeQ) begin
      if (colQ == COL_LAST) begin
        colQ <= '0;
        if (rowQ == ROW_LAST) begin
          rowQ    <= '0;
          activeQ <= 1'b0;
        end else begin
          rowQ <= rowQ + 1'b1;
        end
      end else begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  // reflected coordinates for the 180-degree mode
  always_comb begin
    rowEff = shRot ? (ROW_LAST - rowQ) : rowQ;
    colEff = shRot ? (COL_LAST - colQ) : colQ;
  end

  // stride is a power of two and the base is aligned above it: pure concat
  assign fetchAddr = {shBase, rowEff, colEff, 2'b00};
  assign fetchReq  = strb.dispOn & activeQ;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    assign chan[ch] = fetchReq ? pixWord[ch*CHAN_W +: CHAN_W] : '0;
  end

  assign blue        = chan[0];
  assign green       = chan[1];
  assign red         = chan[2];
  assign unusedAlpha = ^pixWord[31:NUM_CHAN*CHAN_W];

endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen
  import scanout_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int BASE_BITS   = DEF_BASE_BITS,
  parameter int STRIDE_LOG2 = DEF_STRIDE_LOG2,
  parameter int H_PIX       = DEF_H_PIX,
  parameter int V_ROWS      = DEF_V_ROWS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              frameStart,
  input  logic              pixAdvance,
  input  logic [31:0]       pixWord,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReq,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);

  scanStrb_t            strb;
  logic [BASE_BITS-1:0] baseHi;
  logic                 rotSel;

  scanout_ctrl #(
    .ADDR_W    (ADDR_W),
    .BASE_BITS (BASE_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .frameStart (frameStart),
    .pixAdvance (pixAdvance),
    .strb       (strb),
    .baseHi     (baseHi),
    .rotSel     (rotSel)
  );

  scanout_datapath #(
    .ADDR_W      (ADDR_W),
    .BASE_BITS   (BASE_BITS),
    .STRIDE_LOG2 (STRIDE_LOG2),
    .H_PIX       (H_PIX),
    .V_ROWS      (V_ROWS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseHi    (baseHi),
    .rotSel    (rotSel),
    .pixWord   (pixWord),
    .fetchAddr (fetchAddr),
    .fetchReq  (fetchReq),
    .red       (red),
    .green     (green),
    .blue      (blue)
  );

endmodule

// File: rtl/scanout_addr_gen_chk.sv
module scanout_addr_gen_chk
  import scanout_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int BASE_BITS   = DEF_BASE_BITS,
  parameter int STRIDE_LOG2 = DEF_STRIDE_LOG2,
  parameter int H_PIX       = DEF_H_PIX,
  parameter int V_ROWS      = DEF_V_ROWS
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWe,
  input logic                 regAddr,
  input logic [ADDR_W-1:0]    regWdata,
  input logic [ADDR_W-1:0]    regRdata,
  input logic                 frameStart,
  input logic                 pixAdvance,
  input logic [ADDR_W-1:0]    fetchAddr,
  input logic                 fetchReq,
  input logic [7:0]           red,
  input logic [7:0]           green,
  input logic [7:0]           blue,
  input logic [BASE_BITS-1:0] baseHi,
  input logic                 rotSel
);

  localparam int LOW_W = ADDR_W - BASE_BITS;
  localparam int ROW_W = LOW_W - STRIDE_LOG2 - 2;
  localparam logic [LOW_W-1:0] ORIGIN_ROT =
    {ROW_W'(V_ROWS - 1), STRIDE_LOG2'(H_PIX - 1), 2'b00};

  // R2: base readback never shows the dropped low bits
  assert_base_low_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> regRdata[LOW_W-1:0] == '0);

  // R3: control readback has only two live bits
  assert_ctrl_high_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> regRdata[ADDR_W-1:2] == '0);

  // R4: address holds while no step and no restart
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!pixAdvance && !frameStart) |=> $stable(fetchAddr));

  // R8: clearing enable drops the request on the next cycle
  assert_disable_drops_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr && !regWdata[0]) |=> !fetchReq);

  // R8/R9: colour is blank whenever no fetch is requested
  assert_blank_without_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));

  // R7/R11: a frame begins at the origin chosen by the settings held at the pulse
  assert_frame_origin_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (fetchAddr[ADDR_W-1:LOW_W] == $past(baseHi) &&
                    fetchAddr[LOW_W-1:0] == ($past(rotSel) ? ORIGIN_ROT : '0)));

endmodule

bind scanout_addr_gen scanout_addr_gen_chk #(
  .ADDR_W      (ADDR_W),
  .BASE_BITS   (BASE_BITS),
  .STRIDE_LOG2 (STRIDE_LOG2),
  .H_PIX       (H_PIX),
  .V_ROWS      (V_ROWS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .frameStart (frameStart),
  .pixAdvance (pixAdvance),
  .fetchAddr  (fetchAddr),
  .fetchReq   (fetchReq),
  .red        (red),
  .green      (green),
  .blue       (blue),
  .baseHi     (baseHi),
  .rotSel     (rotSel)
);

// File: tb/scanout_addr_gen_tb.sv
module scanout_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        frameStart = 1'b0;
  logic        pixAdvance = 1'b0;
  logic [31:0] pixWord = '0;
  logic [31:0] fetchAddr;
  logic        fetchReq;
  logic [7:0]  red, green, blue;

  logic        sWe = 1'b0;
  logic        sFs = 1'b0;
  logic        sAdv = 1'b0;
  logic [31:0] sRdata, sAddr;
  logic        sReq;
  logic [7:0]  sRed, sGreen, sBlue;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  scanout_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .frameStart(frameStart),
    .pixAdvance(pixAdvance), .pixWord(pixWord), .fetchAddr(fetchAddr),
    .fetchReq(fetchReq), .red(red), .green(green), .blue(blue)
  );

  // reduced geometry (8x4) used only to reach the end of a frame quickly
  scanout_addr_gen #(.H_PIX(8), .V_ROWS(4)) u_small (
    .clk(clk), .rstN(rstN), .regWe(sWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(sRdata), .frameStart(sFs),
    .pixAdvance(sAdv), .pixWord(pixWord), .fetchAddr(sAddr),
    .fetchReq(sReq), .red(sRed), .green(sGreen), .blue(sBlue)
  );

  // {index, write data, expected readback}
  localparam logic [64:0] REG_VEC [6] = '{
    {1'b0, 32'hFFFF_FFFF, 32'hFFE0_0000},
    {1'b0, 32'h1234_5678, 32'h1220_0000},
    {1'b0, 32'h001F_FFFF, 32'h0000_0000},
    {1'b1, 32'hFFFF_FFFC, 32'h0000_0000},
    {1'b1, 32'h0000_0003, 32'h0000_0003},
    {1'b1, 32'h8000_0002, 32'h0000_0002}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic idx, input logic [31:0] d);
    regAddr = idx; regWdata = d; regWe = 1'b1;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic pulseFrame(input logic withAdv);
    frameStart = 1'b1; pixAdvance = withAdv;
    @(posedge clk); #1;
    frameStart = 1'b0; pixAdvance = 1'b0;
  endtask

  task automatic step(input int n);
    pixAdvance = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    pixAdvance = 1'b0;
  endtask

  task automatic sStep(input int n);
    sAdv = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    sAdv = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 fetchReq", {31'd0, fetchReq}, 32'd0);
    check("R1 colour", {8'd0, red, green, blue}, 32'd0);
    regAddr = 1'b0; #1; check("R1 base readback", regRdata, 32'd0);
    regAddr = 1'b1; #1; check("R1 ctrl readback", regRdata, 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2, R3: register table
    for (int i = 0; i < 6; i++) begin
      wrReg(REG_VEC[i][64], REG_VEC[i][63:32]);
      regAddr = REG_VEC[i][64]; #1;
      check(REG_VEC[i][64] ? "R3 ctrl readback" : "R2 base readback",
            regRdata, REG_VEC[i][31:0]);
    end

    // R4, R9: normal scan
    wrReg(1'b0, 32'h1234_5678);
    wrReg(1'b1, 32'h0000_0001);
    pixWord = 32'hAB12_3456;
    pulseFrame(1'b0);
    check("R4 first pixel", fetchAddr, 32'h1220_0000);
    check("R4 request on", {31'd0, fetchReq}, 32'd1);
    check("R9 unpack ignores top byte", {8'd0, red, green, blue}, 32'h0012_3456);
    step(5);
    check("R4 column 5", fetchAddr, 32'h1220_0014);

    // R6: row boundary
    step(634);
    check("R6 last column", fetchAddr, 32'h1220_09FC);
    step(1);
    check("R6 next row", fetchAddr, 32'h1220_1000);

    // R7: mid-frame settings change held off
    wrReg(1'b0, 32'h0000_0000);
    wrReg(1'b1, 32'h0000_0003);
    check("R7 address unchanged", fetchAddr, 32'h1220_1000);
    step(1);
    check("R7 still unrotated", fetchAddr, 32'h1220_1004);

    // R5, R11: restart with simultaneous advance, rotated
    pulseFrame(1'b1);
    check("R11 R5 rotated origin", fetchAddr, 32'h001D_F9FC);
    step(1);
    check("R5 descending", fetchAddr, 32'h001D_F9F8);

    // R8: disable is immediate and blanks colour
    wrReg(1'b1, 32'h0000_0002);
    check("R8 request off", {31'd0, fetchReq}, 32'd0);
    check("R8 colour blank", {8'd0, red, green, blue}, 32'd0);
    step(2);
    wrReg(1'b1, 32'h0000_0003);
    check("R8 scan kept moving", fetchAddr, 32'h001D_F9F0);
    check("R8 request back", {31'd0, fetchReq}, 32'd1);

    // R10: end of frame on the small instance
    sWe = 1'b1; regAddr = 1'b1; regWdata = 32'h1;
    @(posedge clk); #1; sWe = 1'b0;
    sFs = 1'b1; @(posedge clk); #1; sFs = 1'b0;
    sStep(31);
    check("R10 last pixel", sAddr, 32'h0000_301C);
    check("R10 request at last", {31'd0, sReq}, 32'd1);
    sStep(1);
    check("R10 frame ended", {31'd0, sReq}, 32'd0);
    sStep(3);
    check("R10 advances ignored", {31'd0, sReq}, 32'd0);
    sFs = 1'b1; @(posedge clk); #1; sFs = 1'b0;
    check("R10 R11 restart", {sReq, sAddr[30:0]}, 32'h8000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule